// File: doc/BRIEF.md
# Vectored interrupt entry port

This block sits on the processor side of the link to an external vectored interrupt controller. It takes the controller's active-low fast (FIQ) and normal (IRQ) request lines and turns them into active-high requests for the core. Each line can pass through a two-stage synchronizer, or bypass it when the source shares the core clock. When the core begins IRQ entry, it raises a one-cycle request. The port then fetches the handler address from the controller through a four-phase acknowledge/valid handshake and returns it to the core.

The controller's address-valid strobe has its own synchronizer and its own bypass strap, so the handshake works whether the controller is clocked synchronously or asynchronously to the core. When vectored mode is off, an IRQ request completes at once with the fixed legacy vector. FIQ entry always uses a fixed vector. The low or high exception base is selected by a configuration input.

Top module: `vic_entry_port`

## Requirements
- R1: `irq_o` is the inverse of the synchronized `irq_ni`, and `fiq_o` is the inverse of the synchronized `fiq_ni`; out of reset both outputs are 0.
- R2: With `int_sync_bypass_i` high, `irq_o`/`fiq_o` follow their inputs in the same cycle. With it low, a change of input appears after exactly two rising clock edges.
- R3: With `valid_sync_bypass_i` high, the address is captured on the first rising edge at which `vec_valid_i` is high. With it low, the capture happens on the third rising edge after `vec_valid_i` rises.
- R4: A `vec_req_i` pulse while idle with `vectored_en_i` high sets `ack_o` and `busy_o` high after the next rising edge. `ack_o` stays high until the address is captured.
- R5: On capture, `handler_addr_o` becomes {`vec_addr_i`, 2'b00}, `done_o` is high for exactly one cycle, and `ack_o` falls on the same edge.
- R6: After capture, `busy_o` stays high until the synchronized valid is seen low (one edge after `vec_valid_i` falls when bypassed, three edges when not). A `vec_req_i` received while `busy_o` is high is ignored: no new acknowledge follows.
- R7: A `vec_req_i` pulse while idle with `vectored_en_i` low gives `done_o` after the next edge, with `handler_addr_o` = 0x00000018 (`high_vec_i` low) or 0xFFFF0018 (`high_vec_i` high). `ack_o` and `busy_o` stay low.
- R8: `fiq_vec_o` is 0x0000001C with `high_vec_i` low and 0xFFFF001C with it high, regardless of the vector bus or mode.
- R9: In reset, `ack_o`, `busy_o` and `done_o` are 0 and `handler_addr_o` is 0.
- R10: `handler_addr_o` changes only in a cycle where `done_o` is high, and holds its value when `vec_addr_i` changes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fiq_ni | input | 1 | Fast interrupt request from controller, active low |
| irq_ni | input | 1 | Normal interrupt request from controller, active low |
| int_sync_bypass_i | input | 1 | High: request lines skip their synchronizers |
| valid_sync_bypass_i | input | 1 | High: address-valid strobe skips its synchronizer |
| vec_valid_i | input | 1 | Controller holds a valid vector address, active high |
| vec_addr_i | input | 30 | Handler address bits [31:2] |
| vectored_en_i | input | 1 | High: IRQ entry fetches the vector address |
| high_vec_i | input | 1 | High: fixed vectors use the 0xFFFF0000 base |
| vec_req_i | input | 1 | Core pulse: IRQ entry wants a handler address |
| fiq_o | output | 1 | Synchronized fast interrupt request, active high |
| irq_o | output | 1 | Synchronized normal interrupt request, active high |
| ack_o | output | 1 | Acknowledge to controller, active high |
| busy_o | output | 1 | Handshake in progress |
| done_o | output | 1 | One-cycle pulse: `handler_addr_o` is new |
| handler_addr_o | output | 32 | IRQ handler address returned to the core |
| fiq_vec_o | output | 32 | Fixed FIQ vector |

## Verification
Request outputs are due in the same cycle when bypassed and after two edges when synchronized. The bench samples them half a period after each edge and counts edges from the input change. A handshake's `done_o` is due one edge after valid rises when bypassed and three edges after when synchronized. Idle is due one or three edges after valid falls, and a legacy completion one edge after the request. The bench counts falling edges from each stimulus and requires the event at exactly that count, not merely within a window.

// File: rtl/vic_port_pkg.sv
package vic_port_pkg;
  localparam int unsigned VEC_W  = 30;
  localparam int unsigned ADDR_W = 32;
  localparam logic [ADDR_W-1:0] IRQ_VEC_LO = 32'h0000_0018;
  localparam logic [ADDR_W-1:0] IRQ_VEC_HI = 32'hFFFF_0018;
  localparam logic [ADDR_W-1:0] FIQ_VEC_LO = 32'h0000_001C;
  localparam logic [ADDR_W-1:0] FIQ_VEC_HI = 32'hFFFF_001C;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_DRAIN = 2'd2
  } hs_state_e;
endpackage

// File: rtl/vic_sync_cell.sv
module vic_sync_cell #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bypass_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = bypass_i ? d_i : pipe_q[STAGES-1];
endmodule

// File: rtl/vic_req_front.sv
module vic_req_front #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bypass_i,
  input  logic fiq_ni,
  input  logic irq_ni,
  output logic fiq_o,
  output logic irq_o
);
  localparam int unsigned NLINES = 2;

  logic [NLINES-1:0] raw_n;
  logic [NLINES-1:0] sync_n;

  assign raw_n = {fiq_ni, irq_ni};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    // idle level of an active-low line is 1
    vic_sync_cell #(.STAGES(STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .bypass_i (bypass_i),
      .d_i      (raw_n[g]),
      .q_o      (sync_n[g])
    );
  end

  assign irq_o = ~sync_n[0];
  assign fiq_o = ~sync_n[1];
endmodule

// File: rtl/vic_vec_handshake.sv
module vic_vec_handshake
  import vic_port_pkg::*;
#(
  parameter int unsigned VW = VEC_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_s_i,
  input  logic [VW-1:0] vec_addr_i,
  input  logic          vectored_en_i,
  input  logic          high_vec_i,
  input  logic          req_i,
  output logic          ack_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned PAD_W = AW - VW;

  hs_state_e      state_q, state_d;
  logic           done_q, done_d;
  logic [AW-1:0]  addr_q, addr_d;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    addr_d  = addr_q;
    unique case (state_q)
      HS_IDLE: if (req_i) begin
        if (vectored_en_i) begin
          state_d = HS_ACK;
        end else begin
          done_d = 1'b1;
          addr_d = high_vec_i ? IRQ_VEC_HI : IRQ_VEC_LO;
        end
      end
      HS_ACK: if (valid_s_i) begin
        done_d  = 1'b1;
        addr_d  = {vec_addr_i, {PAD_W{1'b0}}};
        state_d = HS_DRAIN;
      end
      HS_DRAIN: if (!valid_s_i) state_d = HS_IDLE;
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      done_q  <= 1'b0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      addr_q  <= addr_d;
    end
  end

  assign ack_o  = (state_q == HS_ACK);
  assign busy_o = (state_q != HS_IDLE);
  assign done_o = done_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/vic_entry_port.sv
module vic_entry_port
  import vic_port_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fiq_ni,
  input  logic              irq_ni,
  input  logic              int_sync_bypass_i,
  input  logic              valid_sync_bypass_i,
  input  logic              vec_valid_i,
  input  logic [VEC_W-1:0]  vec_addr_i,
  input  logic              vectored_en_i,
  input  logic              high_vec_i,
  input  logic              vec_req_i,
  output logic              fiq_o,
  output logic              irq_o,
  output logic              ack_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] handler_addr_o,
  output logic [ADDR_W-1:0] fiq_vec_o
);
  logic valid_s;

  vic_req_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bypass_i (int_sync_bypass_i),
    .fiq_ni   (fiq_ni),
    .irq_ni   (irq_ni),
    .fiq_o    (fiq_o),
    .irq_o    (irq_o)
  );

  vic_sync_cell #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_valid_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bypass_i (valid_sync_bypass_i),
    .d_i      (vec_valid_i),
    .q_o      (valid_s)
  );

  vic_vec_handshake #(.VW(VEC_W), .AW(ADDR_W)) u_hs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .valid_s_i     (valid_s),
    .vec_addr_i    (vec_addr_i),
    .vectored_en_i (vectored_en_i),
    .high_vec_i    (high_vec_i),
    .req_i         (vec_req_i),
    .ack_o         (ack_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .addr_o        (handler_addr_o)
  );

  // FIQ never takes the vectored address
  assign fiq_vec_o = high_vec_i ? FIQ_VEC_HI : FIQ_VEC_LO;
endmodule

// File: rtl/vic_entry_port_chk.sv
module vic_entry_port_chk
  import vic_port_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fiq_ni,
  input logic              irq_ni,
  input logic              int_sync_bypass_i,
  input logic              valid_sync_bypass_i,
  input logic              vec_valid_i,
  input logic [VEC_W-1:0]  vec_addr_i,
  input logic              vectored_en_i,
  input logic              high_vec_i,
  input logic              vec_req_i,
  input logic              fiq_o,
  input logic              irq_o,
  input logic              ack_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] handler_addr_o,
  input logic [ADDR_W-1:0] fiq_vec_o
);
  assert_bypass_irq_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_sync_bypass_i |-> (irq_o == !irq_ni && fiq_o == !fiq_ni));

  assert_ack_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && vec_req_i && vectored_en_i) |=> (ack_o && busy_o));

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_ack_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_o) |-> done_o);

  assert_done_no_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!ack_o && handler_addr_o[1:0] == 2'b00));

  assert_ignore_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ack_o) |=> !ack_o || !busy_o || $stable(ack_o));

  assert_legacy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && vec_req_i && !vectored_en_i) |=> (done_o && !ack_o && !busy_o));

  assert_hold_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(handler_addr_o));
endmodule

bind vic_entry_port vic_entry_port_chk u_chk (.*);

// File: tb/vic_entry_port_tb.sv
`timescale 1ns/1ps
module vic_entry_port_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fiq_ni = 1'b1, irq_ni = 1'b1;
  logic        int_sync_bypass_i = 1'b0, valid_sync_bypass_i = 1'b0;
  logic        vec_valid_i = 1'b0;
  logic [29:0] vec_addr_i = '0;
  logic        vectored_en_i = 1'b0, high_vec_i = 1'b0, vec_req_i = 1'b0;
  logic        fiq_o, irq_o, ack_o, busy_o, done_o;
  logic [31:0] handler_addr_o, fiq_vec_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  vic_entry_port u_dut (.*);

  typedef struct packed {
    logic        vect;
    logic        high;
    logic        byp;
    logic [29:0] addr;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{1'b1, 1'b0, 1'b1, 30'h0000_1234},
    '{1'b1, 1'b1, 1'b0, 30'h2AAA_5555},
    '{1'b0, 1'b0, 1'b1, 30'h3FFF_FFFF},
    '{1'b0, 1'b1, 1'b0, 30'h0000_0001},
    '{1'b1, 1'b0, 1'b0, 30'h3FFF_FFFF},
    '{1'b1, 1'b1, 1'b1, 30'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // count falling edges until done_o, max 8
  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!done_o && n < 8);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (busy_o && n < 8);
  endtask

  task automatic run_entry(input vec_t v);
    int n;
    logic [31:0] exp_addr;
    vectored_en_i = v.vect;
    high_vec_i = v.high;
    valid_sync_bypass_i = v.byp;
    @(negedge clk_i);
    vec_req_i = 1'b1;
    @(negedge clk_i);
    vec_req_i = 1'b0;
    if (!v.vect) begin
      exp_addr = v.high ? 32'hFFFF_0018 : 32'h0000_0018;
      chk("R7 done", {31'd0, done_o}, 32'd1);
      chk("R7 addr", handler_addr_o, exp_addr);
      chk("R7 no ack/busy", {30'd0, ack_o, busy_o}, 32'd0);
    end else begin
      chk("R4 ack after req", {30'd0, ack_o, busy_o}, 32'd3);
      vec_addr_i = v.addr;
      vec_valid_i = 1'b1;
      wait_done(n);
      chk("R3 capture latency", n, v.byp ? 1 : 3);
      chk("R5 addr", handler_addr_o, {v.addr, 2'b00});
      chk("R5 ack dropped", {31'd0, ack_o}, 32'd0);
      @(negedge clk_i);
      chk("R5 done one cycle", {31'd0, done_o}, 32'd0);
      chk("R6 busy after capture", {31'd0, busy_o}, 32'd1);
      vec_valid_i = 1'b0;
      wait_idle(n);
      chk("R6 idle latency", n, v.byp ? 1 : 3);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk("R9 reset ctl", {29'd0, ack_o, busy_o, done_o}, 32'd0);
    chk("R9 reset addr", handler_addr_o, 32'd0);
    chk("R1 reset req", {30'd0, fiq_o, irq_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    foreach (TBL[i]) run_entry(TBL[i]);

    // R1/R2 bypassed requests
    int_sync_bypass_i = 1'b1;
    irq_ni = 1'b0;
    #1;
    chk("R2 bypass irq same cycle", {31'd0, irq_o}, 32'd1);
    fiq_ni = 1'b0;
    #1;
    chk("R2 bypass fiq same cycle", {31'd0, fiq_o}, 32'd1);
    irq_ni = 1'b1;
    fiq_ni = 1'b1;
    #1;
    chk("R1 bypass release", {30'd0, fiq_o, irq_o}, 32'd0);

    // R2 synchronized latency
    int_sync_bypass_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    irq_ni = 1'b0;
    @(negedge clk_i);
    chk("R2 sync irq after 1 edge", {31'd0, irq_o}, 32'd0);
    @(negedge clk_i);
    chk("R1 sync irq after 2 edges", {31'd0, irq_o}, 32'd1);
    fiq_ni = 1'b0;
    irq_ni = 1'b1;
    @(negedge clk_i);
    chk("R2 sync fiq after 1 edge", {31'd0, fiq_o}, 32'd0);
    @(negedge clk_i);
    chk("R1 sync fiq after 2 edges", {30'd0, fiq_o, irq_o}, 32'd2);
    fiq_ni = 1'b1;

    // R8 fixed FIQ vector
    high_vec_i = 1'b0;
    vectored_en_i = 1'b1;
    vec_addr_i = 30'h1555_AAAA;
    #1;
    chk("R8 fiq vec low", fiq_vec_o, 32'h0000_001C);
    high_vec_i = 1'b1;
    #1;
    chk("R8 fiq vec high", fiq_vec_o, 32'hFFFF_001C);

    // R6 request during drain is ignored; R10 hold
    valid_sync_bypass_i = 1'b0;
    @(negedge clk_i);
    vec_req_i = 1'b1;
    @(negedge clk_i);
    vec_req_i = 1'b0;
    vec_addr_i = 30'h0ABC_DEF0;
    vec_valid_i = 1'b1;
    wait_done(n);
    chk("R5 captured", handler_addr_o, {30'h0ABC_DEF0, 2'b00});
    vec_req_i = 1'b1;
    @(negedge clk_i);
    vec_req_i = 1'b0;
    vec_addr_i = 30'h3333_3333;
    vec_valid_i = 1'b0;
    wait_idle(n);
    chk("R6 idle after drain", n, 3);
    repeat (3) @(negedge clk_i);
    chk("R6 request ignored", {30'd0, ack_o, busy_o}, 32'd0);
    chk("R10 addr held", handler_addr_o, {30'h0ABC_DEF0, 2'b00});

    // R7 legacy while valid held low and vectored off, after vectored entry
    vectored_en_i = 1'b0;
    high_vec_i = 1'b0;
    vec_req_i = 1'b1;
    @(negedge clk_i);
    vec_req_i = 1'b0;
    chk("R7 legacy low after vectored", handler_addr_o, 32'h0000_0018);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule